// File: doc/BRIEF.md
# Queued Packet Byte Serializer with Register Front End

This block lets software build outgoing packets through a memory-mapped 32-bit register port. Software first writes all the payload words of a packet to a payload data register, which loads them into a payload queue. It then writes a 24-bit header word, which goes into a separate header queue. The header acts as the trigger: once a header is queued and enough payload words are present, a scheduler takes the packet and a serializer sends it as a byte stream over a valid/ready handshake.

Each packet starts with three header bytes. The first is the type byte (data type in bits [5:0], channel in bits [7:6]). The second and third are the low and high bytes of the 16-bit count field. Long packets then carry exactly `count` payload bytes. These are taken from the queued words starting at byte [7:0] of each word. Unused bytes in the last word are dropped. Short packets use the count field for two parameter bytes and take nothing from the payload queue. A status register reports whether each queue is empty or full. A write to a full queue is held with a low ready until space frees up.

Because a bus write takes a setup cycle and an access cycle, the front end accepts at most one 32-bit word every two clocks. That gives a peak input rate of 16 bits per clock.

Top module: `pkt_fifo_regif`

## Requirements
- R1: After reset the status register reads 0x5, and `tx_valid` is low. Status bit 0 is payload queue empty, bit 1 is payload queue full, bit 2 is header queue empty and bit 3 is header queue full.
- R2: Register offsets are 0x0 for payload data (write), 0x4 for the header (write) and 0x8 for status (read). A read from any other offset returns 0. A write completes in the access phase, in the cycle where `pready` is high.
- R3: `pready` is low only in the access phase of a write whose target queue is full. The write then completes once a slot frees, and no word is lost.
- R4: Every packet begins with three bytes: {hdr[7:6], hdr[5:0]}, then hdr[15:8], then hdr[23:16]. Header bits [31:24] have no effect.
- R5: A packet is long when data type bit 5 and bit 3 are both 1. A long packet is followed by exactly count payload bytes, taken from each word in the order [7:0], [15:8], [23:16], [31:24].
- R6: A short packet is exactly its three header bytes and removes no payload word.
- R7: A packet does not start until the payload queue holds at least ceil(count/4) words. Unused bytes of a long packet's last word are discarded, so the next packet begins on a fresh word.
- R8: `tx_sop` is high on the first header byte only and `tx_eop` is high on the final byte only. Packets go out one at a time, in header order, with at least one idle cycle between them.
- R9: While `tx_valid` is high and `tx_ready` is low, the byte and its flags hold still. Within a packet, `tx_valid` stays high from the first byte to the last.
- R10: The payload queue holds 64 words and the header queue holds 8 headers. The full flags are set at exactly those fill levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write (1) or read (0) |
| paddr | input | 4 | Register byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete; low stalls a write to a full queue |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_sop | output | 1 | First byte of a packet |
| tx_eop | output | 1 | Last byte of a packet |

## Verification
The bench sweeps long packets over counts 0 to 20 and several short and long type codes, under random back-pressure. A design that got this wrong would emit the wrong number of payload bytes, mishandle the odd remainder of the last word, take words from the queue for a short packet, or misplace the start and end flags, and any of these shifts every byte that follows. Separate runs fill the payload queue to 64 words and the header queue to 8 headers with the sink stalled. These runs check the full flags and that a further write is held with `pready` low and later lands intact; a design with an off-by-one depth or a lost stalled write fails here. One test queues a header before its payload is complete. A scheduler that does not wait for the payload would start early and send stale bytes.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  localparam logic [3:0] OFF_PAYLOAD = 4'h0;
  localparam logic [3:0] OFF_HEADER  = 4'h4;
  localparam logic [3:0] OFF_STATUS  = 4'h8;
  localparam int HDR_W = 24;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_HDR = 2'd1, S_PAY = 2'd2} ser_state_t;

  function automatic logic is_long(input logic [5:0] dt);
    return dt[5] & dt[3];
  endfunction
endpackage

// File: rtl/pkt_sync_fifo.sv
module pkt_sync_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [PW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == (PW+1)'(DEPTH));
  assign count   = cnt_q;
  assign rdata   = mem[rptr_q];
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) wptr_d = wptr_q + 1'b1;
    if (do_pop)  rptr_d = rptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end
endmodule

// File: rtl/pkt_apb_regs.sv
module pkt_apb_regs
  import pkt_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  input  logic          pay_empty,
  input  logic          pay_full,
  input  logic          cmd_empty,
  input  logic          cmd_full,
  output logic          pay_push,
  output logic [31:0]   pay_wdata,
  output logic          cmd_push,
  output logic [HDR_W-1:0] cmd_wdata
);
  logic wr_acc, sel_pay, sel_cmd, sel_stat, blocked;

  assign sel_pay  = (paddr == AW'(OFF_PAYLOAD));
  assign sel_cmd  = (paddr == AW'(OFF_HEADER));
  assign sel_stat = (paddr == AW'(OFF_STATUS));
  assign wr_acc   = psel & penable & pwrite;
  assign blocked  = (sel_pay & pay_full) | (sel_cmd & cmd_full);

  assign pready    = ~(wr_acc & blocked);
  assign pay_push  = wr_acc & sel_pay & ~pay_full;
  assign cmd_push  = wr_acc & sel_cmd & ~cmd_full;
  assign pay_wdata = pwdata;
  assign cmd_wdata = pwdata[HDR_W-1:0];

  always_comb begin
    prdata = '0;
    if (psel && !pwrite && sel_stat)
      prdata = {28'd0, cmd_full, cmd_empty, pay_full, pay_empty};
  end
endmodule

// File: rtl/pkt_serializer.sv
module pkt_serializer
  import pkt_fifo_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_empty,
  input  logic [HDR_W-1:0] cmd_head,
  output logic             cmd_pop,
  input  logic [31:0]      pay_head,
  input  logic [CW-1:0]    pay_count,
  output logic             pay_pop,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             tx_sop,
  output logic             tx_eop
);
  ser_state_t       st_q, st_d;
  logic [HDR_W-1:0] hdr_q, hdr_d;
  logic [1:0]       hidx_q, hidx_d;
  logic [15:0]      left_q, left_d;
  logic [1:0]       lane_q, lane_d;

  logic [15:0] head_wc;
  logic [16:0] need_words;
  logic        head_ready, fire, has_pay, last_hdr;

  assign head_wc    = cmd_head[23:8];
  assign need_words = ({1'b0, head_wc} + 17'd3) >> 2;
  assign head_ready = ~cmd_empty &
                      (~is_long(cmd_head[5:0]) | ({{(17-CW){1'b0}}, pay_count} >= need_words));
  assign has_pay    = is_long(hdr_q[5:0]) & (hdr_q[23:8] != 16'd0);
  assign last_hdr   = (hidx_q == 2'd2);
  assign tx_valid   = (st_q != S_IDLE);
  assign fire       = tx_valid & tx_ready;
  assign tx_sop     = (st_q == S_HDR) & (hidx_q == 2'd0);

  always_comb begin
    tx_data = 8'd0;
    tx_eop  = 1'b0;
    if (st_q == S_HDR) begin
      case (hidx_q)
        2'd0:    tx_data = hdr_q[7:0];
        2'd1:    tx_data = hdr_q[15:8];
        default: tx_data = hdr_q[23:16];
      endcase
      tx_eop = last_hdr & ~has_pay;
    end else if (st_q == S_PAY) begin
      tx_data = pay_head[8*lane_q +: 8];
      tx_eop  = (left_q == 16'd1);
    end
  end

  always_comb begin
    st_d    = st_q;
    hdr_d   = hdr_q;
    hidx_d  = hidx_q;
    left_d  = left_q;
    lane_d  = lane_q;
    cmd_pop = 1'b0;
    pay_pop = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (head_ready) begin
          cmd_pop = 1'b1;
          hdr_d   = cmd_head;
          hidx_d  = 2'd0;
          st_d    = S_HDR;
        end
      end
      S_HDR: begin
        if (fire) begin
          if (last_hdr) begin
            left_d = hdr_q[23:8];
            lane_d = 2'd0;
            st_d   = has_pay ? S_PAY : S_IDLE;
          end else begin
            hidx_d = hidx_q + 2'd1;
          end
        end
      end
      S_PAY: begin
        if (fire) begin
          left_d = left_q - 16'd1;
          lane_d = lane_q + 2'd1;
          if (lane_q == 2'd3 || left_q == 16'd1) pay_pop = 1'b1;
          if (left_q == 16'd1) st_d = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      hdr_q  <= '0;
      hidx_q <= '0;
      left_q <= '0;
      lane_q <= '0;
    end else begin
      st_q   <= st_d;
      hdr_q  <= hdr_d;
      hidx_q <= hidx_d;
      left_q <= left_d;
      lane_q <= lane_d;
    end
  end
endmodule

// File: rtl/pkt_fifo_regif.sv
module pkt_fifo_regif
  import pkt_fifo_pkg::*;
#(
  parameter int AW        = 4,
  parameter int PAY_DEPTH = 64,
  parameter int CMD_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_sop,
  output logic          tx_eop
);
  localparam int PCW = $clog2(PAY_DEPTH) + 1;
  localparam int CCW = $clog2(CMD_DEPTH) + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             pay_push, pay_pop, pay_empty, pay_full;
  logic             cmd_push, cmd_pop, cmd_empty, cmd_full;
  logic [31:0]      pay_wdata, pay_head;
  logic [HDR_W-1:0] cmd_wdata, cmd_head;
  logic [PCW-1:0]   pay_count;
  logic [CCW-1:0]   cmd_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  pkt_apb_regs #(.AW(AW)) u_regs (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pay_empty(pay_empty), .pay_full(pay_full),
    .cmd_empty(cmd_empty), .cmd_full(cmd_full),
    .pay_push(pay_push), .pay_wdata(pay_wdata),
    .cmd_push(cmd_push), .cmd_wdata(cmd_wdata)
  );

  pkt_sync_fifo #(.W(32), .DEPTH(PAY_DEPTH)) u_pay_q (
    .clk(clk), .rst_n(rst_n_int), .push(pay_push), .wdata(pay_wdata),
    .pop(pay_pop), .rdata(pay_head), .empty(pay_empty), .full(pay_full),
    .count(pay_count)
  );

  pkt_sync_fifo #(.W(HDR_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk(clk), .rst_n(rst_n_int), .push(cmd_push), .wdata(cmd_wdata),
    .pop(cmd_pop), .rdata(cmd_head), .empty(cmd_empty), .full(cmd_full),
    .count(cmd_count)
  );

  pkt_serializer #(.CW(PCW)) u_ser (
    .clk(clk), .rst_n(rst_n_int),
    .cmd_empty(cmd_empty), .cmd_head(cmd_head), .cmd_pop(cmd_pop),
    .pay_head(pay_head), .pay_count(pay_count), .pay_pop(pay_pop),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_sop(tx_sop), .tx_eop(tx_eop)
  );

  logic unused_cnt;
  assign unused_cnt = ^cmd_count;
endmodule

// File: rtl/pkt_fifo_regif_chk.sv
module pkt_fifo_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       psel,
  input logic       penable,
  input logic       pwrite,
  input logic       pready,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_sop,
  input logic       tx_eop
);
  p_stall_only_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pready |-> (psel && penable && pwrite));

  p_hold_when_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

  p_no_gap_in_packet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !tx_eop) |=> tx_valid);

  p_idle_after_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_eop) |=> !tx_valid);

  p_start_has_sop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_sop);

  p_flags_need_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sop || tx_eop) |-> tx_valid);
endmodule

bind pkt_fifo_regif pkt_fifo_regif_chk u_chk (.*);

// File: tb/test_pkt_fifo_regif.sv
module test_pkt_fifo_regif;
  logic clk, rst_n, psel, penable, pwrite, tx_ready;
  logic [3:0] paddr;
  logic [31:0] pwdata, prdata;
  logic pready, tx_valid, tx_sop, tx_eop;
  logic [7:0] tx_data;

  int n_chk = 0, n_fail = 0, rmode = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [9:0] exp_q[$], got_q[$];

  pkt_fifo_regif i_pkt_fifo_regif (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_sop(tx_sop), .tx_eop(tx_eop));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rmode)
      0: tx_ready = 1'b0;
      1: tx_ready = 1'b1;
      default: tx_ready = lfsr[0] | lfsr[5];
    endcase
    if (rst_n && tx_valid && tx_ready) got_q.push_back({tx_sop, tx_eop, tx_data});
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int seed, input int k);
    return 8'((seed * 29 + k * 7 + k / 5 + 3) & 255);
  endfunction

  task automatic apb_write(input logic [3:0] a, input logic [31:0] d, output int stalls);
    stalls = 0;
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    forever begin
      #1;
      if (pready) begin
        @(posedge clk);
        break;
      end
      stalls++;
      @(negedge clk);
    end
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(posedge clk);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic push_words(input int seed, input int wc, input int first_w, input int n_w);
    int st;
    for (int w = first_w; w < first_w + n_w; w++) begin
      logic [31:0] word;
      for (int b = 0; b < 4; b++) word[8*b +: 8] = pbyte(seed, 4*w + b);
      apb_write(4'h0, word, st);
    end
  endtask

  // header layout: [5:0] type, [7:6] channel, [23:8] count; long iff type bit5 and bit3 (R5)
  task automatic push_header(input logic [5:0] dt, input logic [1:0] vc, input logic [15:0] wc, input int seed);
    int st;
    bit lng;
    lng = dt[5] & dt[3];
    apb_write(4'h4, {8'hA5, wc, vc, dt}, st);
    exp_q.push_back({1'b1, 1'b0, vc, dt});
    exp_q.push_back({2'b00, wc[7:0]});
    exp_q.push_back({1'b0, !(lng && wc != 0), wc[15:8]});
    if (lng)
      for (int k = 0; k < int'(wc); k++)
        exp_q.push_back({1'b0, k == int'(wc) - 1, pbyte(seed, k)});
  endtask

  task automatic send_pkt(input logic [5:0] dt, input logic [1:0] vc, input logic [15:0] wc, input int seed);
    if (dt[5] & dt[3]) push_words(seed, wc, 0, (int'(wc) + 3) / 4);
    push_header(dt, vc, wc, seed);
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (got_q.size() < exp_q.size() && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (8) @(negedge clk);
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, {22'd0, got_q[i]}, {22'd0, exp_q[i]});
    exp_q.delete();
    got_q.delete();
  endtask

  initial begin
    int t = 0;
    while (t < 150000) begin
      @(posedge clk);
      t++;
    end
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", t);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int st;
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    tx_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    apb_read(4'h8, rd);
    chk(rd == 32'h5, "R1 status", rd, 32'h5);
    chk(tx_valid == 1'b0, "R1 tx_valid", {31'd0, tx_valid}, 0);
    // R2 unmapped and write-only offsets read 0
    apb_read(4'hC, rd);
    chk(rd == 0, "R2 unmapped read", rd, 0);
    apb_read(4'h0, rd);
    chk(rd == 0, "R2 payload offset read", rd, 0);

    // R5 R7 long packet sweep over counts 0..20, random back-pressure
    rmode = 2;
    for (int wc = 0; wc <= 20; wc++) send_pkt(6'h39, 2'(wc), 16'(wc), wc + 1);
    drain("R5 R7 long sweep");

    // R4 R6 short types, including type codes with only one of the two long bits set
    send_pkt(6'h05, 2'd1, 16'h1234, 0);
    send_pkt(6'h21, 2'd2, 16'hBEEF, 0);
    send_pkt(6'h0D, 2'd3, 16'h0001, 0);
    send_pkt(6'h37, 2'd0, 16'hFFFF, 0);
    send_pkt(6'h29, 2'd1, 16'd5, 77);
    send_pkt(6'h2E, 2'd2, 16'd3, 78);
    send_pkt(6'h3E, 2'd3, 16'd9, 79);
    drain("R4 R6 type mix");
    apb_read(4'h8, rd);
    chk(rd == 32'h5, "R6 no payload left after short packets", rd, 32'h5);

    // R7 header queued before its payload is complete
    rmode = 1;
    push_words(200, 8, 0, 1);
    push_header(6'h39, 2'd0, 16'd8, 200);
    repeat (30) @(negedge clk);
    chk(got_q.size() == 0, "R7 no start before payload", got_q.size(), 0);
    push_words(200, 8, 1, 1);
    drain("R7 late payload");

    // R10 R3 payload queue full and stalled write
    rmode = 0;
    send_pkt(6'h39, 2'd1, 16'd256, 5);
    repeat (4) @(negedge clk);
    apb_read(4'h8, rd);
    chk(rd == 32'h6, "R10 payload full", rd, 32'h6);
    fork
      begin
        logic [31:0] w;
        for (int b = 0; b < 4; b++) w[8*b +: 8] = pbyte(9, b);
        apb_write(4'h0, w, st);
      end
      begin
        repeat (12) @(negedge clk);
        #1 chk(pready == 1'b0, "R3 pready low on full", {31'd0, pready}, 0);
        rmode = 1;
      end
    join
    chk(st >= 10, "R3 write was stalled", st, 10);
    push_header(6'h39, 2'd2, 16'd3, 9);
    drain("R3 stalled word delivered");

    // R10 header queue full
    rmode = 0;
    for (int i = 0; i < 9; i++) push_header(6'h05, 2'(i), 16'(i * 257 + 1), 0);
    repeat (4) @(negedge clk);
    apb_read(4'h8, rd);
    chk(rd == 32'h9, "R10 header full", rd, 32'h9);
    rmode = 2;
    drain("R8 R9 queued short packets");

    apb_read(4'h8, rd);
    chk(rd == 32'h5, "R2 status after drain", rd, 32'h5);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule